// File: doc/BRIEF.md
# PWM Pair Conversion-Start Selector

This block sits between one pair of PWM channel counters and an ADC. It watches the event strobes of the pair's even and odd channel: counter at zero, counter at period, compare match while counting up, and compare match while counting down. It also watches the pair's shared counter value and count direction. A 4-bit source code picks one condition, and the block turns that condition into a single-clock start-of-conversion pulse for the ADC.

The source codes cover more than single strobes. One code per channel fires on zero or period. A separate 16-bit trigger comparator, shared by both channels of the pair, fires when the counter reaches its value while counting in a chosen direction. A value written to this comparator goes into a pending register and becomes active at the next period boundary. The even channel's zero strobe marks that boundary.

Each pulse also sets a sticky flag, which software clears by writing one. The block is built once per channel pair. The `PAIR_ID` parameter tells it which pair of comparator codes belongs to it.

Top module: `adc_trig_select`

## Requirements
- R1: Source codes 0 to 4 select the even channel's zero strobe (0), period strobe (1), zero-or-period (2), compare-while-up strobe (3) and compare-while-down strobe (4).
- R2: Source codes 5 to 9 select the same five conditions, in the same order, taken from the odd channel.
- R3: The zero-or-period codes (2 and 7) fire when either strobe is present. When both strobes arrive in the same clock, they produce exactly one pulse.
- R4: Code 10+2*PAIR_ID fires when the counter equals the active comparator value while counting up (`cnt_up`=1). Code 11+2*PAIR_ID does the same while counting down. In both cases only the first cycle of an unbroken run of such a match fires.
- R5: Comparator codes that belong to another pair (codes 10 to 15 outside this pair's two) never produce a pulse.
- R6: A write to the comparator is held pending. The pending value becomes active on the clock where `ev_even_zero` is high, and the active value changes at no other time.
- R7: While `trig_en` is low, no pulse is produced and the flag is not set.
- R8: `adc_trig` is high for the single clock that follows each cycle in which the selected condition was true with `trig_en` high.
- R9: `trig_flag` goes high together with each pulse and stays high until a cycle with `flag_clr` high. If a pulse is generated in the same cycle as a clear, the set wins.
- R10: After reset, `adc_trig` and `trig_flag` are low, and both the pending and the active comparator values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_en | input | 1 | Trigger enable |
| src_sel | input | 4 | Trigger source code |
| ev_even_zero | input | 1 | Even channel counter reached zero |
| ev_even_prd | input | 1 | Even channel counter reached period |
| ev_even_cmpu | input | 1 | Even channel compare match, counting up |
| ev_even_cmpd | input | 1 | Even channel compare match, counting down |
| ev_odd_zero | input | 1 | Odd channel counter reached zero |
| ev_odd_prd | input | 1 | Odd channel counter reached period |
| ev_odd_cmpu | input | 1 | Odd channel compare match, counting up |
| ev_odd_cmpd | input | 1 | Odd channel compare match, counting down |
| cnt_val | input | 16 | Pair counter value |
| cnt_up | input | 1 | Count direction, 1 = up |
| ftc_wr | input | 1 | Write strobe for the trigger comparator |
| ftc_wdata | input | 16 | Trigger comparator write value |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| adc_trig | output | 1 | Start-of-conversion pulse |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The assertions check three things on every cycle. No pulse follows a cycle with the enable low. The flag is high whenever a pulse is, and it only falls after a clear. The active comparator value moves only on a period-boundary strobe, and it then takes the pending value.

Other behaviours are shown only by the bench's scenarios, where a model predicts each output. These are the mapping of all sixteen codes onto their conditions and the single pulse for simultaneous zero and period strobes. They also include the first-cycle-only firing of the direction-qualified comparator, the one-period delay before a newly written value takes effect, and set-over-clear on the flag.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int SRC_W   = 4;
    localparam int N_CONDS = 5;

    typedef enum logic [SRC_W-1:0] {
        SRC_E_ZERO = 4'd0,
        SRC_E_PRD  = 4'd1,
        SRC_E_ZOP  = 4'd2,
        SRC_E_CUP  = 4'd3,
        SRC_E_CDN  = 4'd4,
        SRC_O_ZERO = 4'd5,
        SRC_O_PRD  = 4'd6,
        SRC_O_ZOP  = 4'd7,
        SRC_O_CUP  = 4'd8,
        SRC_O_CDN  = 4'd9,
        SRC_F0_UP  = 4'd10,
        SRC_F0_DN  = 4'd11,
        SRC_F1_UP  = 4'd12,
        SRC_F1_DN  = 4'd13,
        SRC_F2_UP  = 4'd14,
        SRC_F2_DN  = 4'd15
    } trig_src_e;

    // Per-channel event strobes
    typedef struct packed {
        logic zero;
        logic prd;
        logic cmp_up;
        logic cmp_dn;
    } chan_ev_t;

    // First free-comparator code, shifted right by one (10 >> 1)
    localparam int FREE_CODE_HALF = 5;

endpackage

// File: rtl/ftc_shadow_reg.sv
module ftc_shadow_reg #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    input  logic             load,
    output logic [CMP_W-1:0] act_val
);

    typedef struct packed {
        logic [CMP_W-1:0] pend;
        logic [CMP_W-1:0] act;
    } shd_t;

    shd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the load takes the value that was pending before this cycle's write
        if (load)  st_d.act  = st_q.pend;
        if (wr_en) st_d.pend = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_val = st_q.act;

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_val));

    // R6
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act_val == $past(st_q.pend)));

endmodule

// File: rtl/ftc_dir_match.sv
module ftc_dir_match #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic [CMP_W-1:0] cmp_val,
    output logic             fire_up,
    output logic             fire_dn
);

    typedef struct packed {
        logic hit_up;
        logic hit_dn;
    } hit_t;

    hit_t h_d, h_q;
    logic eq;

    always_comb begin
        eq          = (cnt_val == cmp_val);
        h_d.hit_up  = eq &&  cnt_up;
        h_d.hit_dn  = eq && !cnt_up;
        // fire only on arrival, not while the counter dwells on the value
        fire_up     = h_d.hit_up && !h_q.hit_up;
        fire_dn     = h_d.hit_dn && !h_q.hit_dn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
    import adc_trig_pkg::*;
#(
    parameter int PAIR_ID = 0
) (
    input  logic [SRC_W-1:0] src_sel,
    input  chan_ev_t         ev_even,
    input  chan_ev_t         ev_odd,
    input  logic             fire_up,
    input  logic             fire_dn,
    output logic             hit
);

    localparam int FREE_BASE = FREE_CODE_HALF + PAIR_ID;
    localparam int N_CH      = 2;

    logic [N_CONDS-1:0] cond [N_CH];
    chan_ev_t           ev_arr [N_CH];

    assign ev_arr[0] = ev_even;
    assign ev_arr[1] = ev_odd;

    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_ch
            always_comb begin
                cond[ch][0] = ev_arr[ch].zero;
                cond[ch][1] = ev_arr[ch].prd;
                cond[ch][2] = ev_arr[ch].zero | ev_arr[ch].prd;
                cond[ch][3] = ev_arr[ch].cmp_up;
                cond[ch][4] = ev_arr[ch].cmp_dn;
            end
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        if (src_sel < SRC_W'(N_CONDS)) begin
            hit = cond[0][src_sel[2:0]];
        end else if (src_sel < SRC_W'(2*N_CONDS)) begin
            hit = cond[1][3'(src_sel - SRC_W'(N_CONDS))];
        end else if (src_sel[SRC_W-1:1] == (SRC_W-1)'(FREE_BASE)) begin
            hit = src_sel[0] ? fire_dn : fire_up;
        end
    end

endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_trig_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PAIR_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_en,
    input  logic [3:0]       src_sel,
    input  logic             ev_even_zero,
    input  logic             ev_even_prd,
    input  logic             ev_even_cmpu,
    input  logic             ev_even_cmpd,
    input  logic             ev_odd_zero,
    input  logic             ev_odd_prd,
    input  logic             ev_odd_cmpu,
    input  logic             ev_odd_cmpd,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic             ftc_wr,
    input  logic [CNT_W-1:0] ftc_wdata,
    input  logic             flag_clr,
    output logic             adc_trig,
    output logic             trig_flag
);

    localparam int FREE_BASE = FREE_CODE_HALF + PAIR_ID;

    typedef struct packed {
        logic pulse;
        logic flag;
    } out_t;

    chan_ev_t         ev_e, ev_o;
    logic [CNT_W-1:0] ftc_act;
    logic             f_up, f_dn, sel_hit;
    out_t             o_d, o_q;

    assign ev_e = '{zero: ev_even_zero, prd: ev_even_prd, cmp_up: ev_even_cmpu, cmp_dn: ev_even_cmpd};
    assign ev_o = '{zero: ev_odd_zero,  prd: ev_odd_prd,  cmp_up: ev_odd_cmpu,  cmp_dn: ev_odd_cmpd};

    ftc_shadow_reg #(.CMP_W(CNT_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ftc_wr),
        .wr_data (ftc_wdata),
        .load    (ev_even_zero),
        .act_val (ftc_act)
    );

    ftc_dir_match #(.CMP_W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_val (cnt_val),
        .cnt_up  (cnt_up),
        .cmp_val (ftc_act),
        .fire_up (f_up),
        .fire_dn (f_dn)
    );

    trig_src_mux #(.PAIR_ID(PAIR_ID)) u_mux (
        .src_sel (src_sel),
        .ev_even (ev_e),
        .ev_odd  (ev_o),
        .fire_up (f_up),
        .fire_dn (f_dn),
        .hit     (sel_hit)
    );

    always_comb begin
        o_d.pulse = trig_en && sel_hit;
        o_d.flag  = o_q.flag;
        if (flag_clr)  o_d.flag = 1'b0;
        if (o_d.pulse) o_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign adc_trig  = o_q.pulse;
    assign trig_flag = o_q.flag;

    // R7
    no_trig_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !adc_trig);

    // R9
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> trig_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !flag_clr) |=> trig_flag);

    // R9
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_flag) |-> $past(flag_clr));

    // R5
    other_pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_sel[3:1] >= 3'(FREE_CODE_HALF)) && (src_sel[3:1] != 3'(FREE_BASE))) |=> !adc_trig);

endmodule

// File: tb/sim_adc_trig_select.sv
module sim_adc_trig_select;

    localparam int  CLK_P   = 10;
    localparam int  CNT_W   = 16;
    localparam int  PAIR_ID = 0;
    localparam int  N_RAND  = 3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic trig_en, ev_even_zero, ev_even_prd, ev_even_cmpu, ev_even_cmpd;
    logic ev_odd_zero, ev_odd_prd, ev_odd_cmpu, ev_odd_cmpd;
    logic [3:0] src_sel;
    logic [CNT_W-1:0] cnt_val, ftc_wdata;
    logic cnt_up, ftc_wr, flag_clr, adc_trig, trig_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [CNT_W-1:0] m_pend, m_act;
    logic m_hup, m_hdn, m_flag;

    always #(CLK_P/2) clk = ~clk;

    adc_trig_select #(.CNT_W(CNT_W), .PAIR_ID(PAIR_ID)) u0 (.*);

    function automatic logic exp_sel(input logic [3:0] s, input logic fu, input logic fd);
        logic [4:0] ce, co;
        ce = {ev_even_cmpd, ev_even_cmpu, ev_even_zero | ev_even_prd, ev_even_prd, ev_even_zero};
        co = {ev_odd_cmpd,  ev_odd_cmpu,  ev_odd_zero  | ev_odd_prd,  ev_odd_prd,  ev_odd_zero};
        if (s < 5)                          return ce[s];
        if (s < 10)                         return co[s-5];
        if (int'(s) == 10 + 2*PAIR_ID)      return fu;
        if (int'(s) == 11 + 2*PAIR_ID)      return fd;
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        {ev_even_zero, ev_even_prd, ev_even_cmpu, ev_even_cmpd} = '0;
        {ev_odd_zero, ev_odd_prd, ev_odd_cmpu, ev_odd_cmpd} = '0;
        ftc_wr = 0; flag_clr = 0; ftc_wdata = '0;
    endtask

    // Predict, clock once, compare at the next falling edge, advance model
    task automatic step(input string req);
        logic hup, hdn, fu, fd, e_trig, e_flag;
        hup = (cnt_val == m_act) &&  cnt_up;
        hdn = (cnt_val == m_act) && !cnt_up;
        fu  = hup && !m_hup;
        fd  = hdn && !m_hdn;
        e_trig = trig_en && exp_sel(src_sel, fu, fd);
        e_flag = e_trig ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
        @(posedge clk); @(negedge clk);
        check(req, "adc_trig", adc_trig, e_trig);
        check(req, "trig_flag", trig_flag, e_flag);
        m_hup = hup; m_hdn = hdn; m_flag = e_flag;
        if (ev_even_zero) m_act = m_pend;
        if (ftc_wr) m_pend = ftc_wdata;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle(); trig_en = 1; src_sel = 4'd0; cnt_val = 16'd9; cnt_up = 1;
        m_pend = '0; m_act = '0; m_hup = 0; m_hdn = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check("R10", "adc_trig after reset", adc_trig, 1'b0);
        check("R10", "trig_flag after reset", trig_flag, 1'b0);
        step("R10");
        // R10 active compare value is zero: counter 0 counting up fires code 10
        src_sel = 4'd10; cnt_val = '0; step("R10");
        check("R10", "pulse from zero compare", adc_trig, 1'b1);
        // R4 dwelling on the match gives no second pulse
        step("R4");
        check("R4", "no repeat while dwelling", adc_trig, 1'b0);
        // R4 down direction, code 11
        src_sel = 4'd11; cnt_val = 16'd3; step("R4");
        cnt_up = 0; cnt_val = '0; step("R4");
        check("R4", "down match fires", adc_trig, 1'b1);
        // R9 clear, then clear with simultaneous event (set wins)
        cnt_val = 16'd7; flag_clr = 1; step("R9");
        check("R9", "flag cleared", trig_flag, 1'b0);
        src_sel = 4'd2; ev_even_zero = 1; step("R9");
        check("R9", "set wins over clear", trig_flag, 1'b1);
        // R3 zero and period together: one pulse, then nothing
        flag_clr = 0; ev_even_prd = 1; step("R3");
        check("R3", "zero-or-period fires", adc_trig, 1'b1);
        idle(); step("R8");
        check("R8", "pulse lasts one clock", adc_trig, 1'b0);
        // R1 / R2 a couple of directed strobes
        src_sel = 4'd3; ev_even_cmpu = 1; step("R1");
        idle(); src_sel = 4'd9; ev_odd_cmpd = 1; step("R2");
        check("R2", "odd compare-down fires", adc_trig, 1'b1);
        // R6 write 5, not active until the even zero strobe
        idle(); src_sel = 4'd10; cnt_up = 1; cnt_val = 16'd1;
        ftc_wr = 1; ftc_wdata = 16'd5; step("R6");
        ftc_wr = 0; cnt_val = 16'd5; step("R6");
        check("R6", "pending value not yet active", adc_trig, 1'b0);
        cnt_val = 16'd2; ev_even_zero = 1; step("R6");
        ev_even_zero = 0; cnt_val = 16'd5; step("R6");
        check("R6", "value active after period boundary", adc_trig, 1'b1);
        // R5 another pair's code stays silent on a fresh match
        cnt_val = 16'd1; step("R5");
        src_sel = 4'd12; cnt_val = 16'd5; step("R5");
        check("R5", "other pair code silent", adc_trig, 1'b0);
        // R7 enable low blocks pulse and flag
        flag_clr = 1; step("R7"); flag_clr = 0;
        trig_en = 0; src_sel = 4'd5; ev_odd_zero = 1; step("R7");
        check("R7", "flag not set while disabled", trig_flag, 1'b0);
        idle(); trig_en = 1;

        for (int i = 0; i < N_RAND; i++) begin
            string tag;
            src_sel = 4'($urandom_range(0, 15));
            {ev_even_zero, ev_even_prd, ev_even_cmpu, ev_even_cmpd} = 4'($urandom) & 4'($urandom);
            {ev_odd_zero, ev_odd_prd, ev_odd_cmpu, ev_odd_cmpd}     = 4'($urandom) & 4'($urandom);
            cnt_val   = CNT_W'($urandom_range(0, 7));
            cnt_up    = 1'($urandom);
            ftc_wr    = ($urandom_range(0, 7) == 0);
            ftc_wdata = CNT_W'($urandom_range(0, 7));
            flag_clr  = ($urandom_range(0, 7) == 0);
            trig_en   = ($urandom_range(0, 7) != 0);
            if (!trig_en)          tag = "R7";
            else if (src_sel < 5)  tag = "R1";
            else if (src_sel < 10) tag = "R2";
            else if (src_sel < 12) tag = "R4";
            else                   tag = "R5";
            step(tag);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule